// File: doc/BRIEF.md
# Multi-Mode General-Purpose Timer

A 16-bit timer that a processor configures through a simple word-addressed register port. It can run as a one-shot or periodic counter in either direction, or as a PWM generator. It can also act as a capture unit that either timestamps edges on an input pin or counts them. Several of these timers can be chained: a timer can wait for a pulse from the timer before it before it starts counting, and each time-out sends a pulse on to the next timer.

The mode register is frozen while the timer runs. Software sets the load and match values, writes the mode, and then sets the enable bit. Status is reported through three sticky flags: time-out, match and capture. The flags are cleared by writing 1, and the interrupt line is the OR of all three.

Register word addresses are: 0 mode, 1 control (bit 0 enable), 2 load, 3 match, 4 live count (read only), 5 value (read only), 6 flags. The flag bits are: bit 0 time-out, bit 1 match, bit 2 capture.

Top module: `gp_timer`

## Requirements
- R1: The mode register has this layout: bit 7 snapshot enable, bit 6 wait-on-trigger, bit 5 match interrupt enable, bit 4 count up, bit 3 PWM select, bit 2 edge-time select, bits 1:0 operating mode (0 idle, 1 one-shot, 2 periodic, 3 capture). Bits 31:8 read as zero.
- R2: A write to the mode register while the enable bit is set leaves the mode register unchanged.
- R3: Counting down in one-shot or periodic mode starts from the load value L. A time-out occurs on the tick after the count reaches zero. The first time-out pulse appears on trig_o L+2 cycles after the enabling write, and pulses then repeat every L+1 cycles. Each pulse lasts one cycle and sets flag bit 0.
- R4: With count up set in one-shot or periodic mode, the count starts at 0, times out on reaching the load value, and restarts from 0. The timing is the same as in R3.
- R5: In one-shot mode the time-out clears the enable bit, so exactly one trig_o pulse is produced.
- R6: With wait-on-trigger set, an enabled timer holds its count until a trig_i pulse arrives.
- R7: With snapshot enable set in periodic mode, each time-out copies the live count into the value register.
- R8: Flag bit 1 is set when the count equals the match value in one-shot or periodic mode, but only if match interrupt enable is set.
- R9: PWM runs only when PWM select is 1, edge-time select is 0 and the mode is 1 or 2. The counter then counts down periodically from L, and pwm_o is high while the count is above the match value M, which is L-M cycles in every L+1. In any other configuration pwm_o stays low.
- R10: In edge-time capture, the count free-runs down. A rising edge on cap_i, after a two-flop synchronizer, copies the count into the value register and sets flag bit 2. The copied value is the count sampled just before the edge minus 2.
- R11: In edge-count capture, each rising edge on cap_i decrements the count starting from L. The edge that takes the count to the match value sets flag bit 2 and reloads L.
- R12: Writing 1 to a flag bit clears it, while bits written with 0 are kept. irq_o is high while any flag is set.
- R13: After reset all registers, trig_o, pwm_o and irq_o are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data (combinational from address) |
| trig_i | input | 1 | Start pulse from the previous timer in the chain |
| trig_o | output | 1 | Time-out pulse to the next timer |
| cap_i | input | 1 | Asynchronous capture pin |
| pwm_o | output | 1 | PWM output |
| irq_o | output | 1 | Interrupt, OR of the flags |

## Verification
The enabling write loads the count one cycle later, and the first tick follows in the next cycle. A time-out is therefore seen on trig_o and the flags L+2 cycles after the write, and the bench looks for it at exactly that offset, sampling on the falling edge. A pin edge reaches the capture logic three rising edges after it is applied, so the expected captured value is the count read in the same falling-edge slot minus 2. Results that depend on the phase of the waveform, such as PWM duty and pulse counts, are measured over whole periods, so the expected totals hold at any starting point.

// File: rtl/gpt_pkg.sv
package gpt_pkg;
  typedef enum logic [1:0] {
    MD_IDLE     = 2'd0,
    MD_ONESHOT  = 2'd1,
    MD_PERIODIC = 2'd2,
    MD_CAPTURE  = 2'd3
  } md_e;

  // packed MSB first: snap at bit 7 ... md at bits 1:0
  typedef struct packed {
    logic snap;
    logic wot;
    logic mie;
    logic up;
    logic alt_pwm;
    logic cap_time;
    md_e  md;
  } mode_t;

  localparam logic [2:0] A_MODE  = 3'd0;
  localparam logic [2:0] A_CTRL  = 3'd1;
  localparam logic [2:0] A_LOAD  = 3'd2;
  localparam logic [2:0] A_MATCH = 3'd3;
  localparam logic [2:0] A_COUNT = 3'd4;
  localparam logic [2:0] A_VALUE = 3'd5;
  localparam logic [2:0] A_FLAGS = 3'd6;

  localparam int unsigned NFLAG = 3;
endpackage

// File: rtl/gpt_regs.sv
module gpt_regs
  import gpt_pkg::*;
#(
  parameter int unsigned CW = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [2:0]       addr_i,
  input  logic [31:0]      wdata_i,
  input  logic             en_clr_i,
  input  logic [NFLAG-1:0] flag_set_i,
  output mode_t            mode_o,
  output logic             en_o,
  output logic [CW-1:0]    load_o,
  output logic [CW-1:0]    match_o,
  output logic [NFLAG-1:0] flags_o
);
  logic [NFLAG-1:0] w1c;

  assign w1c = (we_i && addr_i == A_FLAGS) ? wdata_i[NFLAG-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o  <= '0;
      en_o    <= 1'b0;
      load_o  <= '0;
      match_o <= '0;
      flags_o <= '0;
    end else begin
      if (we_i && addr_i == A_MODE && !en_o) mode_o <= mode_t'(wdata_i[7:0]);
      if (we_i && addr_i == A_CTRL) en_o <= wdata_i[0];
      else if (en_clr_i)            en_o <= 1'b0;
      if (we_i && addr_i == A_LOAD)  load_o  <= wdata_i[CW-1:0];
      if (we_i && addr_i == A_MATCH) match_o <= wdata_i[CW-1:0];
      flags_o <= (flags_o & ~w1c) | flag_set_i;
    end
  end

  generate
    if (CW < 32) begin : g_hi
      logic unused_hi;
      assign unused_hi = ^wdata_i[31:CW];
    end
  endgenerate
endmodule

// File: rtl/gpt_sync.sv
module gpt_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic rise_o
);
  localparam int unsigned TOP = STAGES;

  logic [TOP:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[TOP-1:0], pin_i};
  end

  assign rise_o = sr_q[TOP-1] & ~sr_q[TOP];
endmodule

// File: rtl/gpt_core.sv
module gpt_core
  import gpt_pkg::*;
#(
  parameter int unsigned CW = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  mode_t            mode_i,
  input  logic             en_i,
  input  logic [CW-1:0]    load_i,
  input  logic [CW-1:0]    match_i,
  input  logic             trig_i,
  input  logic             cap_rise_i,
  output logic [CW-1:0]    count_o,
  output logic [CW-1:0]    value_o,
  output logic [NFLAG-1:0] flag_set_o,
  output logic             stop_o,
  output logic             trig_o,
  output logic             pwm_o
);
  logic en_q, run_q;
  logic tmr_md, pwm_sel, tmr_sel, cap_sel, edge_time, edge_cnt;
  logic up, free_run, periodic, start, active, tick, at_end, tmo;
  logic match_hit, et_hit, ec_hit;
  logic [CW-1:0] cnt_dec, cnt_inc;

  assign tmr_md    = (mode_i.md == MD_ONESHOT) || (mode_i.md == MD_PERIODIC);
  assign pwm_sel   = tmr_md && mode_i.alt_pwm && !mode_i.cap_time;
  assign tmr_sel   = tmr_md && !pwm_sel;
  assign cap_sel   = mode_i.md == MD_CAPTURE;
  assign edge_time = cap_sel && mode_i.cap_time;
  assign edge_cnt  = cap_sel && !mode_i.cap_time;
  assign up        = tmr_sel && mode_i.up;
  assign free_run  = tmr_sel || pwm_sel || edge_time;
  assign periodic  = pwm_sel || edge_time || (mode_i.md == MD_PERIODIC);

  assign start  = en_i && !en_q;
  assign active = en_i && en_q && run_q;
  assign tick   = active && free_run;
  assign at_end = up ? (count_o == load_i) : (count_o == '0);
  assign tmo    = tick && at_end;

  assign cnt_dec = count_o - 1'b1;
  assign cnt_inc = count_o + 1'b1;

  assign match_hit = tick && tmr_sel && mode_i.mie && (count_o == match_i);
  assign et_hit    = active && edge_time && cap_rise_i;
  assign ec_hit    = active && edge_cnt && cap_rise_i && (cnt_dec == match_i);

  assign stop_o     = tmo && tmr_sel && (mode_i.md == MD_ONESHOT);
  assign flag_set_o = {et_hit || ec_hit, match_hit, tmo};
  assign pwm_o      = pwm_sel && active && (count_o > match_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      run_q   <= 1'b0;
      count_o <= '0;
      value_o <= '0;
      trig_o  <= 1'b0;
    end else begin
      en_q   <= en_i;
      trig_o <= tmo;
      // daisy-chain gate: armed at start unless waiting for the previous stage
      if (!en_i)              run_q <= 1'b0;
      else if (start)         run_q <= !mode_i.wot;
      else if (!run_q && trig_i) run_q <= 1'b1;

      if (start) begin
        count_o <= up ? '0 : load_i;
      end else if (tick) begin
        if (at_end) begin
          if (periodic) count_o <= up ? '0 : load_i;
        end else begin
          count_o <= up ? cnt_inc : cnt_dec;
        end
      end else if (active && edge_cnt && cap_rise_i) begin
        count_o <= ec_hit ? load_i : cnt_dec;
      end

      if (et_hit)
        value_o <= count_o;
      else if (tmo && mode_i.snap && tmr_sel && mode_i.md == MD_PERIODIC)
        value_o <= count_o;
    end
  end
endmodule

// File: rtl/gp_timer.sv
module gp_timer
  import gpt_pkg::*;
#(
  parameter int unsigned CW       = 16,
  parameter int unsigned SYNC_STG = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic [2:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  input  logic        trig_i,
  output logic        trig_o,
  input  logic        cap_i,
  output logic        pwm_o,
  output logic        irq_o
);
  mode_t            mode_q;
  logic             en_w, os_stop, cap_rise;
  logic [CW-1:0]    load_w, match_w, count_w, value_w;
  logic [NFLAG-1:0] flags_w, fset_w;

  gpt_regs #(.CW(CW)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (reg_we_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .en_clr_i  (os_stop),
    .flag_set_i(fset_w),
    .mode_o    (mode_q),
    .en_o      (en_w),
    .load_o    (load_w),
    .match_o   (match_w),
    .flags_o   (flags_w)
  );

  gpt_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pin_i (cap_i),
    .rise_o(cap_rise)
  );

  gpt_core #(.CW(CW)) u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mode_i    (mode_q),
    .en_i      (en_w),
    .load_i    (load_w),
    .match_i   (match_w),
    .trig_i    (trig_i),
    .cap_rise_i(cap_rise),
    .count_o   (count_w),
    .value_o   (value_w),
    .flag_set_o(fset_w),
    .stop_o    (os_stop),
    .trig_o    (trig_o),
    .pwm_o     (pwm_o)
  );

  always_comb begin
    unique case (reg_addr_i)
      A_MODE:  reg_rdata_o = {24'd0, mode_q};
      A_CTRL:  reg_rdata_o = {31'd0, en_w};
      A_LOAD:  reg_rdata_o = 32'(load_w);
      A_MATCH: reg_rdata_o = 32'(match_w);
      A_COUNT: reg_rdata_o = 32'(count_w);
      A_VALUE: reg_rdata_o = 32'(value_w);
      A_FLAGS: reg_rdata_o = 32'(flags_w);
      default: reg_rdata_o = '0;
    endcase
  end

  assign irq_o = |flags_w;
endmodule

// File: rtl/gp_timer_chk.sv
module gp_timer_chk #(
  parameter int unsigned CW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [7:0]    mode_i,
  input logic          en_i,
  input logic          ctrl_wr_i,
  input logic          stop_i,
  input logic          trig_i,
  input logic [2:0]    flags_i,
  input logic          pwm_i,
  input logic [CW-1:0] count_i
);
  logic unused_bits;
  logic tmr_md, pwm_cfg, up_tmr;

  assign unused_bits = ^mode_i[7:5];
  assign tmr_md  = (mode_i[1:0] == 2'd1) || (mode_i[1:0] == 2'd2);
  assign pwm_cfg = tmr_md && mode_i[3] && !mode_i[2];
  assign up_tmr  = tmr_md && !pwm_cfg && mode_i[4];

  assert_mode_frozen_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && $past(en_i)) |-> $stable(mode_i));

  assert_trig_flag_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_i |-> flags_i[0]);

  assert_up_from_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(en_i) && up_tmr) |=> (count_i == '0));

  assert_en_fall_cause_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(en_i) |-> $past(ctrl_wr_i || stop_i));

  assert_pwm_gated_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwm_cfg |-> !pwm_i);
endmodule

bind gp_timer gp_timer_chk #(.CW(CW)) chk_i (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .mode_i   (mode_q),
  .en_i     (en_w),
  .ctrl_wr_i(reg_we_i && (reg_addr_i == gpt_pkg::A_CTRL)),
  .stop_i   (os_stop),
  .trig_i   (trig_o),
  .flags_i  (flags_w),
  .pwm_i    (pwm_o),
  .count_i  (count_w)
);

// File: tb/gp_timer_tb_top.sv
module gp_timer_tb_top;
  import gpt_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        trig_in = 1'b0;
  logic        trig_out;
  logic        cap = 1'b0;
  logic        pwm;
  logic        irq;
  int          n_chk = 0;
  int          n_fail = 0;

  always #10 clk = ~clk;

  gp_timer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .trig_i(trig_in),
    .trig_o(trig_out), .cap_i(cap), .pwm_o(pwm), .irq_o(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output int d);
    @(negedge clk);
    addr = a;
    #1 d = int'(rdata);
  endtask

  task automatic setup(input logic [31:0] md, input int ld, input int mt);
    wr(A_CTRL, 0);
    wr(A_FLAGS, 7);
    wr(A_LOAD, ld);
    wr(A_MATCH, mt);
    wr(A_MODE, md);
    wr(A_CTRL, 1);
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // time-out timing sweep: first pulse at L+2, period L+1
  task automatic sweep(input int lv, input bit up_m);
    int first = -1;
    int second = -1;
    int c1 = -1;
    setup(up_m ? 32'h12 : 32'h02, lv, 16'hFFFF);
    addr = A_COUNT;
    for (int i = 1; i <= 3 * lv + 8; i++) begin
      @(negedge clk);
      if (i == 1) c1 = int'(rdata);
      if (trig_out) begin
        if (first < 0) first = i;
        else if (second < 0) second = i;
      end
    end
    if (up_m) begin
      chk("R4 start count", c1, 0);
      chk("R4 first time-out", first, lv + 2);
      chk("R4 period", second - first, lv + 1);
    end else begin
      chk("R3 start count", c1, lv);
      chk("R3 first time-out", first, lv + 2);
      chk("R3 period", second - first, lv + 1);
    end
  endtask

  task automatic pwm_duty(input logic [31:0] md, input int lv, input int mt, input int exp, input string tag);
    int hi = 0;
    setup(md, lv, mt);
    wait_cyc(2 * lv + 6);
    for (int i = 0; i < 4 * (lv + 1); i++) begin
      @(negedge clk);
      if (pwm) hi++;
    end
    chk(tag, hi, exp);
  endtask

  task automatic cap_pulse();
    @(negedge clk); cap = 1'b1;
    wait_cyc(3);
    cap = 1'b0;
    wait_cyc(3);
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    int v, c0, pulses;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R13 reset state
    for (int a = 0; a < 7; a++) begin
      rd(3'(a), v);
      chk("R13 register reset", v, 0);
    end
    chk("R13 trig_o reset", int'(trig_out), 0);
    chk("R13 pwm_o reset", int'(pwm), 0);
    chk("R13 irq_o reset", int'(irq), 0);

    // R1 layout: reserved bits read zero
    wr(A_MODE, 32'hFFFF_FFFF);
    rd(A_MODE, v);
    chk("R1 mode width", v, 32'hFF);
    wr(A_MODE, 0);

    for (int l = 0; l <= 6; l++) sweep(l, 1'b0);
    for (int l = 1; l <= 5; l++) sweep(l, 1'b1);

    // R2 mode frozen while enabled
    setup(32'h02, 50, 16'hFFFF);
    wr(A_MODE, 32'h01);
    rd(A_MODE, v);
    chk("R2 mode write ignored", v, 32'h02);

    // R5 one-shot
    setup(32'h01, 3, 16'hFFFF);
    pulses = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (trig_out) pulses++;
    end
    chk("R5 single pulse", pulses, 1);
    rd(A_CTRL, v);
    chk("R5 enable cleared", v, 0);
    rd(A_FLAGS, v);
    chk("R5 time-out flag", v & 1, 1);

    // R6 wait-on-trigger
    setup(32'h42, 2, 16'hFFFF);
    pulses = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (trig_out) pulses++;
    end
    chk("R6 no pulse before trigger", pulses, 0);
    rd(A_COUNT, v);
    chk("R6 count held", v, 2);
    @(negedge clk); trig_in = 1'b1;
    @(negedge clk); trig_in = 1'b0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (trig_out) pulses++;
    end
    chk("R6 runs after trigger", int'(pulses >= 1), 1);

    // R7 snapshot in periodic count-up
    setup(32'h92, 9, 16'hFFFF);
    wait_cyc(25);
    rd(A_VALUE, v);
    chk("R7 snapshot value", v, 9);

    // R8 match flag gated by enable bit
    setup(32'h21, 10, 4);
    wait_cyc(20);
    rd(A_FLAGS, v);
    chk("R8 match flag set", (v >> 1) & 1, 1);
    setup(32'h01, 10, 4);
    wait_cyc(20);
    rd(A_FLAGS, v);
    chk("R8 match flag masked", (v >> 1) & 1, 0);
    chk("R8 time-out still flagged", v & 1, 1);

    // R9 PWM duty sweep
    for (int m = 0; m <= 6; m++) pwm_duty(32'h0A, 7, m, 4 * (7 - m), "R9 duty periodic");
    pwm_duty(32'h09, 7, 3, 16, "R9 duty one-shot field");
    pwm_duty(32'h0E, 7, 3, 0, "R9 disabled by edge-time bit");
    pwm_duty(32'h0B, 7, 3, 0, "R9 disabled in capture mode");

    // R10 edge-time capture
    setup(32'h07, 1000, 0);
    wait_cyc(5);
    @(negedge clk);
    addr = A_COUNT;
    #1 c0 = int'(rdata);
    cap = 1'b1;
    wait_cyc(5);
    cap = 1'b0;
    rd(A_VALUE, v);
    chk("R10 captured count", v, c0 - 2);
    rd(A_FLAGS, v);
    chk("R10 capture flag", (v >> 2) & 1, 1);

    // R11 edge-count capture
    setup(32'h03, 5, 2);
    wait_cyc(3);
    cap_pulse();
    cap_pulse();
    rd(A_COUNT, v);
    chk("R11 count after two edges", v, 3);
    rd(A_FLAGS, v);
    chk("R11 no flag yet", (v >> 2) & 1, 0);
    cap_pulse();
    rd(A_FLAGS, v);
    chk("R11 flag at match", (v >> 2) & 1, 1);
    rd(A_COUNT, v);
    chk("R11 reload after match", v, 5);

    // R12 write-one-to-clear
    wr(A_CTRL, 0);
    rd(A_FLAGS, v);
    chk("R12 flags before clear", v, 4);
    chk("R12 irq high", int'(irq), 1);
    wr(A_FLAGS, 32'h3);
    rd(A_FLAGS, v);
    chk("R12 zero bits kept", v, 4);
    wr(A_FLAGS, 32'h4);
    rd(A_FLAGS, v);
    chk("R12 flag cleared", v, 0);
    chk("R12 irq low", int'(irq), 0);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule